// File: doc/BRIEF.md
# Overwriting Host-Read Header Buffer

This block is a circular byte store for side-channel header bytes that a stream parser extracts. The parser offers one byte per cycle on a write port that has no ready signal. Every byte offered while capture is enabled is stored. The buffer is never drained automatically. Bytes leave only when the host asks for them through a read request, and a byte that nobody reads stays in place for as long as no newer data arrives.

When the store is full and another byte arrives, the oldest unread byte is discarded to make room, and a sticky lost-data flag tells the host that it fell behind. The host can empty the store at any time with a software clear. The clear also drops the lost flag. The block drives no flow-control signal, so its fill state cannot stall or throttle the main stream.

Top module: `hdr_ring_buf`

## Requirements
- R1: After a cycle with `rst` high, `rd_valid` is 0, `rd_data` is 0, `lost_flag` is 0 and the store is empty.
- R2: A byte on `wr_data` with `wr_valid` and `cap_en` both high is stored. Host reads return the stored bytes oldest first.
- R3: A byte offered while `cap_en` is low is not stored. A later read of an otherwise empty store returns nothing.
- R4: A read request on a non-empty store gives `rd_valid` high for exactly the next cycle, with the oldest byte on `rd_data`. `rd_data` keeps its value in cycles without a read request.
- R5: A read request on an empty store gives `rd_valid` low and `rd_data` 0 on the next cycle and consumes nothing. This also applies when a write arrives in the same cycle: that byte is stored and returned by the following read.
- R6: A write into a full store with no read in the same cycle is always accepted. It discards the oldest unread byte and sets `lost_flag`, which stays high until a clear or reset.
- R7: When a full store sees a read and a write in the same cycle, the read returns the oldest byte, the new byte is kept, and `lost_flag` is not set.
- R8: `sw_clr` empties the store, sets `rd_data` to 0, `rd_valid` to 0 and `lost_flag` to 0 on the next cycle, and overrides any write or read in the same cycle.
- R9: Stored bytes remain readable unchanged after any number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Capture enable; bytes are ignored while low |
| wr_valid | input | 1 | Parser byte strobe |
| wr_data | input | DW | Parser header byte |
| rd_req | input | 1 | Host read request, one byte per cycle |
| sw_clr | input | 1 | Software clear of the store and the lost flag |
| rd_data | output | DW | Byte returned to the host, 0 after an empty read |
| rd_valid | output | 1 | High for one cycle when `rd_data` carries a stored byte |
| lost_flag | output | 1 | Sticky flag: unread data was overwritten |

## Verification
A wrong occupancy count or pointer shows up at the host port on the very next read. An over-count returns a stale byte with `rd_valid` high where the model expects an empty read. An under-count reports empty while the model still holds bytes. A pointer slip returns the wrong byte in a run of reads. Overwrite bookkeeping is exposed by filling past capacity: the first read after that must return the oldest surviving byte, and `lost_flag` must rise in the cycle after the first overflowing write. The model is compared with all three outputs on every clock, so each such fault is reported in the cycle it first becomes visible.

// File: rtl/hdr_buf_pkg.sv
package hdr_buf_pkg;
  // Pointer action chosen each cycle by the control logic.
  typedef enum logic [2:0] {
    ACT_HOLD,   // nothing moves
    ACT_PUSH,   // store a byte
    ACT_POP,    // hand a byte to the host
    ACT_SWAP,   // read and write together, occupancy unchanged
    ACT_OVWR    // full and writing: drop the oldest byte
  } buf_act_e;
endpackage

// File: rtl/hdr_buf_ram.sv
module hdr_buf_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  input  logic          zero,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // Read-first output register with synchronous clear
  always_ff @(posedge clk) begin
    if (rst || zero) q <= '0;
    else if (re)     q <= mem[ra];
  end
endmodule

// File: rtl/hdr_buf_ctl.sv
module hdr_buf_ctl
  import hdr_buf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_fire,
  input  logic          rd_req,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic          mem_zero,
  output logic [AW:0]   occ,
  output logic          lost
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam bit          POW2     = (DEPTH == (1 << AW));

  logic [AW-1:0] wp, rp, wp_nx, rp_nx;
  logic          empty, full, rd_take;
  buf_act_e      act;

  generate
    if (POW2) begin : g_wrap_free
      assign wp_nx = wp + AW'(1);
      assign rp_nx = rp + AW'(1);
    end else begin : g_wrap_cmp
      assign wp_nx = (wp == AW'(DEPTH-1)) ? '0 : wp + AW'(1);
      assign rp_nx = (rp == AW'(DEPTH-1)) ? '0 : rp + AW'(1);
    end
  endgenerate

  assign empty   = (occ == '0);
  assign full    = (occ == FULL_CNT);
  assign rd_take = rd_req && !empty;

  always_comb begin
    if (clr)                     act = ACT_HOLD;
    else if (wr_fire && rd_take) act = ACT_SWAP;
    else if (wr_fire && full)    act = ACT_OVWR;
    else if (wr_fire)            act = ACT_PUSH;
    else if (rd_take)            act = ACT_POP;
    else                         act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp   <= '0;
      rp   <= '0;
      occ  <= '0;
      lost <= 1'b0;
    end else begin
      case (act)
        ACT_PUSH: begin wp <= wp_nx; occ <= occ + 1'b1; end
        ACT_POP:  begin rp <= rp_nx; occ <= occ - 1'b1; end
        ACT_SWAP: begin wp <= wp_nx; rp <= rp_nx; end
        ACT_OVWR: begin wp <= wp_nx; rp <= rp_nx; lost <= 1'b1; end
        default:  ;
      endcase
    end
  end

  assign wr_addr  = wp;
  assign rd_addr  = rp;
  assign mem_we   = wr_fire && !clr && !rst;
  assign mem_re   = rd_take && !clr;
  assign mem_zero = clr || (rd_req && empty);
endmodule

// File: rtl/hdr_ring_buf.sv
module hdr_ring_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  input  logic          sw_clr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          lost_flag
);
  localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);

  logic [AW-1:0] wr_addr, rd_addr;
  logic          mem_we, mem_re, mem_zero;
  logic [AW:0]   occ;
  logic          wr_fire;

  assign wr_fire = wr_valid && cap_en;

  hdr_buf_ctl #(.DEPTH(DEPTH), .AW(AW)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .clr      (sw_clr),
    .wr_fire  (wr_fire),
    .rd_req   (rd_req),
    .wr_addr  (wr_addr),
    .rd_addr  (rd_addr),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_zero (mem_zero),
    .occ      (occ),
    .lost     (lost_flag)
  );

  hdr_buf_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk  (clk),
    .rst  (rst),
    .we   (mem_we),
    .wa   (wr_addr),
    .wd   (wr_data),
    .re   (mem_re),
    .ra   (rd_addr),
    .zero (mem_zero),
    .q    (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= mem_re;
  end
endmodule

// File: rtl/hdr_ring_buf_chk.sv
module hdr_ring_buf_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cap_en,
  input logic          wr_valid,
  input logic          rd_req,
  input logic          sw_clr,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          lost_flag,
  input logic [AW:0]   occ
);
  // R8
  clr_effect_chk: assert property (@(posedge clk) disable iff (rst)
    sw_clr |=> (!rd_valid && !lost_flag && rd_data == '0 && occ == '0));

  // R4
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req && !sw_clr));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_req && !sw_clr) |=> $stable(rd_data));

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && occ == '0 && !sw_clr) |=> (!rd_valid && rd_data == '0));

  // R6
  lost_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (lost_flag && !sw_clr) |=> lost_flag);

  // R6
  lost_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lost_flag) |-> $past(occ == (AW+1)'(DEPTH) && wr_valid && cap_en && !rd_req));

  // R3
  gated_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cap_en && !rd_req && !sw_clr) |=> $stable(occ));

  // R6
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= (AW+1)'(DEPTH));
endmodule

bind hdr_ring_buf hdr_ring_buf_chk #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cap_en    (cap_en),
  .wr_valid  (wr_valid),
  .rd_req    (rd_req),
  .sw_clr    (sw_clr),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .lost_flag (lost_flag),
  .occ       (occ)
);

// File: tb/sim_hdr_ring_buf.sv
`timescale 1ns/1ps
module sim_hdr_ring_buf;
  localparam int DW    = 8;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cap_en = 1'b0, wr_valid = 1'b0, rd_req = 1'b0, sw_clr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, lost_flag;

  always #5 clk = ~clk;

  hdr_ring_buf #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .cap_en(cap_en), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .sw_clr(sw_clr), .rd_data(rd_data), .rd_valid(rd_valid),
    .lost_flag(lost_flag)
  );

  // Behavioural model
  logic [DW-1:0] q[$];
  logic [DW-1:0] e_data = '0;
  logic          e_valid = 1'b0, e_lost = 1'b0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic step(input bit wv, input logic [DW-1:0] wd, input bit ce,
                      input bit rr, input bit clr, input string tag);
    wr_valid = wv; wr_data = wd; cap_en = ce; rd_req = rr; sw_clr = clr;
    @(posedge clk);
    if (rst || clr) begin
      q.delete(); e_data = '0; e_valid = 0; e_lost = 0;
    end else begin
      e_valid = 0;
      if (rr) begin
        if (q.size() > 0) begin e_data = q.pop_front(); e_valid = 1; end
        else e_data = '0;
      end
      if (wv && ce) begin
        if (q.size() == DEPTH) begin void'(q.pop_front()); e_lost = 1; end
        q.push_back(wd);
      end
    end
    @(negedge clk);
    n_cmp++;
    if (rd_data !== e_data || rd_valid !== e_valid || lost_flag !== e_lost) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h exp %h, rd_valid=%b exp %b, lost_flag=%b exp %b",
               tag, rd_data, e_data, rd_valid, e_valid, lost_flag, e_lost);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, '0, 1, 0, 0, tag);
  endtask

  task automatic wr(input logic [DW-1:0] d, input string tag);
    step(1, d, 1, 0, 0, tag);
  endtask

  task automatic rd(input string tag);
    step(0, '0, 1, 1, 0, tag);
  endtask

  initial begin
    @(negedge clk);
    rst = 1;
    step(1, 8'hAA, 1, 1, 0, "R1");
    step(0, '0, 0, 0, 0, "R1");
    rst = 0;
    idle(2, "R1");
    // R5: empty read
    rd("R5");
    rd("R5");
    // R2: ordered storage and reads
    for (int i = 0; i < 5; i++) wr(8'h10 + 8'(i), "R2");
    for (int i = 0; i < 6; i++) rd("R2");
    // R3: capture disabled
    for (int i = 0; i < 3; i++) step(1, 8'h55, 0, 0, 0, "R3");
    rd("R3");
    // R4: data held without requests
    wr(8'h77, "R4"); rd("R4"); idle(3, "R4");
    // R9: long idle retention
    wr(8'hC1, "R9"); wr(8'hC2, "R9");
    idle(300, "R9");
    rd("R9"); rd("R9"); rd("R9");
    // R6: overflow drops oldest, sticky lost
    for (int i = 0; i < DEPTH + 3; i++) wr(8'h20 + 8'(i), "R6");
    idle(2, "R6");
    for (int i = 0; i < DEPTH + 1; i++) rd("R6");
    // R8: clear with concurrent write and read
    wr(8'h31, "R8"); wr(8'h32, "R8");
    step(1, 8'h33, 1, 1, 1, "R8");
    rd("R8"); idle(1, "R8");
    // R7: full store with simultaneous read and write
    for (int i = 0; i < DEPTH; i++) wr(8'h40 + 8'(i), "R7");
    for (int i = 0; i < 4; i++) step(1, 8'h60 + 8'(i), 1, 1, 0, "R7");
    for (int i = 0; i < DEPTH + 1; i++) rd("R7");
    // R5: empty read with same-cycle write
    step(1, 8'h99, 1, 1, 0, "R5");
    rd("R5");
    // Clear, then mixed traffic
    step(0, '0, 1, 0, 1, "R8");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[15:8], r[2] | r[3] | r[4], r[5] & r[6], (r[20:13] == 8'h00), "R2");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end, actual hung, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule